// File: doc/BRIEF.md
# Nonrestoring Division Step Unit

This block performs a single iteration of a nonrestoring binary division each time it is issued, in the way a processor's one-bit divide-step instruction would. It takes a divisor, a partial remainder, and a shift-in bit. It keeps two status bits of its own: a quotient-polarity bit Q and a divisor-sign bit M. It returns the updated partial remainder, the new Q, and a result bit T that carries one quotient bit per step. Software runs the step repeatedly, rotating each T back into the dividend's low word, and so assembles the quotient.

Two setup operations prepare the status bits before a run. The unsigned setup clears Q, M and T. The signed setup loads Q and M from the sign bits of the operands. The add-or-subtract decision for a step depends only on whether the stored Q matches M. The sign of the remainder plays no part in it.

Top module: `nrdiv_step`

## Requirements
- R1: After reset, res_valid is 0, rem_out is 0, and q_out, m_out and t_out are all 0.
- R2: op_kind 2'b01 (unsigned setup) with op_valid clears Q, M and T, and sets rem_out to rem_in.
- R3: op_kind 2'b10 (signed setup) with op_valid sets Q to rem_in's MSB, M to divisor's MSB and T to Q XOR M. It sets rem_out to rem_in.
- R4: op_kind 2'b00 (step) forms {rem_in[W-2:0], t_in}. When the stored Q equals M it subtracts the divisor from that word, and otherwise it adds the divisor. rem_out is the W-bit truncated result.
- R5: A step sets the new Q to rem_in's MSB XOR c XOR M. Here c is the borrow out of the subtraction or the carry out of the addition.
- R6: After a step, T is 1 exactly when the new Q equals M. M is left unchanged by a step.
- R7: Results appear on the clock edge after the issuing edge. res_valid is high for exactly one cycle per accepted operation.
- R8: With op_valid low, or with op_kind 2'b11, rem_out, Q, M and T keep their values and res_valid stays 0.
- R9: An unsigned setup is followed by W steps. Before each step, the dividend word's MSB is used as t_in and the previous T is rotated into that word's LSB, and a final rotate follows the last step. The dividend word then holds the unsigned quotient, provided the starting partial remainder is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Issue strobe for an operation |
| op_kind | input | 2 | 00 step, 01 unsigned setup, 10 signed setup, 11 reserved |
| divisor | input | W | Divisor operand |
| rem_in | input | W | Partial remainder or dividend high word |
| t_in | input | 1 | Bit shifted into the partial remainder's LSB on a step |
| res_valid | output | 1 | One-cycle pulse marking new results |
| rem_out | output | W | Updated partial remainder |
| q_out | output | 1 | Stored Q bit |
| m_out | output | 1 | Stored M bit |
| t_out | output | 1 | T bit (quotient bit after a step) |

## Verification
The bench builds the unit at its default width of 32 bits. At that width the borrow and carry out of bit 31 are exercised, as are full-range dividends such as 0xFFFFFFFF and 0x80000000 and divisors with the top bit set. It also runs the thirty-two-step loop that software would use for a full word. The four signed-setup sign combinations drive Q and M into every pairing, so both the add path and the subtract path are taken under each value of M.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        OP_STEP   = 2'b00,
        OP_INIT_U = 2'b01,
        OP_INIT_S = 2'b10,
        OP_RSVD   = 2'b11
    } nrdiv_op_e;

endpackage

// File: rtl/nrdiv_shift.sv
// Left shift of the partial remainder with a serial bit entering at the LSB.
module nrdiv_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] word_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         msb_o
);
    assign word_o = {word_i[W-2:0], bit_i};
    assign msb_o  = word_i[W-1];
endmodule

// File: rtl/nrdiv_addsub.sv
// Shared adder: subtract when sub_i, else add; c_o is borrow or carry.
module nrdiv_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] b_ext;
    logic [WX-1:0] sum;

    always_comb begin
        if (sub_i) begin
            b_ext = ~{1'b0, b_i};
            sum   = {1'b0, a_i} + b_ext + {{(WX-1){1'b0}}, 1'b1};
        end else begin
            b_ext = {1'b0, b_i};
            sum   = {1'b0, a_i} + b_ext;
        end
    end

    assign res_o = sum[W-1:0];
    assign c_o   = sum[W];
endmodule

// File: rtl/nrdiv_flags.sv
// New Q and T for a step.
module nrdiv_flags (
    input  logic prov_q_i,
    input  logic c_i,
    input  logic m_i,
    output logic q_o,
    output logic t_o
);
    always_comb begin
        q_o = prov_q_i ^ c_i ^ m_i;
        t_o = (q_o == m_i);
    end
endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [1:0]   op_kind,
    input  logic [W-1:0] divisor,
    input  logic [W-1:0] rem_in,
    input  logic         t_in,
    output logic         res_valid,
    output logic [W-1:0] rem_out,
    output logic         q_out,
    output logic         m_out,
    output logic         t_out
);
    import nrdiv_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] rem;
        logic         q;
        logic         m;
        logic         t;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] shifted_w;
    logic         prov_q_w;
    logic         sub_sel_w;
    logic [W-1:0] as_res_w;
    logic         as_c_w;
    logic         step_q_w;
    logic         step_t_w;

    nrdiv_shift #(.W(W)) u_shift (
        .word_i (rem_in),
        .bit_i  (t_in),
        .word_o (shifted_w),
        .msb_o  (prov_q_w)
    );

    assign sub_sel_w = (st_q.q == st_q.m);

    nrdiv_addsub #(.W(W)) u_addsub (
        .a_i   (shifted_w),
        .b_i   (divisor),
        .sub_i (sub_sel_w),
        .res_o (as_res_w),
        .c_o   (as_c_w)
    );

    nrdiv_flags u_flags (
        .prov_q_i (prov_q_w),
        .c_i      (as_c_w),
        .m_i      (st_q.m),
        .q_o      (step_q_w),
        .t_o      (step_t_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (op_valid) begin
            unique case (nrdiv_op_e'(op_kind))
                OP_STEP: begin
                    st_d.vld = 1'b1;
                    st_d.rem = as_res_w;
                    st_d.q   = step_q_w;
                    st_d.t   = step_t_w;
                end
                OP_INIT_U: begin
                    st_d.vld = 1'b1;
                    st_d.rem = rem_in;
                    st_d.q   = 1'b0;
                    st_d.m   = 1'b0;
                    st_d.t   = 1'b0;
                end
                OP_INIT_S: begin
                    st_d.vld = 1'b1;
                    st_d.rem = rem_in;
                    st_d.q   = rem_in[W-1];
                    st_d.m   = divisor[W-1];
                    st_d.t   = rem_in[W-1] ^ divisor[W-1];
                end
                default: begin
                    st_d.vld = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.vld;
    assign rem_out   = st_q.rem;
    assign q_out     = st_q.q;
    assign m_out     = st_q.m;
    assign t_out     = st_q.t;
endmodule

// File: rtl/nrdiv_step_chk.sv
module nrdiv_step_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [1:0]   op_kind,
    input logic [W-1:0] divisor,
    input logic [W-1:0] rem_in,
    input logic         t_in,
    input logic         res_valid,
    input logic [W-1:0] rem_out,
    input logic         q_out,
    input logic         m_out,
    input logic         t_out
);
    logic acc;
    assign acc = op_valid && (op_kind != 2'b11);

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(acc));

    p_init_u_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01) |=>
            (!q_out && !m_out && !t_out && rem_out == $past(rem_in)));

    p_init_s_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b10) |=>
            (q_out == $past(rem_in[W-1]) && m_out == $past(divisor[W-1])
             && t_out == (q_out ^ m_out)));

    p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00 && q_out == m_out) |=>
            rem_out == ($past({rem_in[W-2:0], t_in}) - $past(divisor)));

    p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00 && q_out != m_out) |=>
            rem_out == ($past({rem_in[W-2:0], t_in}) + $past(divisor)));

    p_t_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00) |=> (t_out == (q_out == m_out)));

    p_m_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00) |=> $stable(m_out));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!res_valid && $stable(rem_out) && $stable(q_out)
                  && $stable(m_out) && $stable(t_out)));
endmodule

bind nrdiv_step nrdiv_step_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .divisor   (divisor),
    .rem_in    (rem_in),
    .t_in      (t_in),
    .res_valid (res_valid),
    .rem_out   (rem_out),
    .q_out     (q_out),
    .m_out     (m_out),
    .t_out     (t_out)
);

// File: tb/nrdiv_step_tb.sv
module nrdiv_step_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_kind = 2'b00;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] rem_in = '0;
    logic         t_in = 1'b0;
    logic         res_valid;
    logic [W-1:0] rem_out;
    logic         q_out, m_out, t_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] rem;
        logic q, m, t;
        string tag;
    } exp_t;

    exp_t sb[$];
    logic mq = 1'b0, mm = 1'b0;

    always #10 clk = ~clk;

    nrdiv_step #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .divisor(divisor), .rem_in(rem_in), .t_in(t_in),
        .res_valid(res_valid), .rem_out(rem_out),
        .q_out(q_out), .m_out(m_out), .t_out(t_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model_step(logic [W-1:0] r, logic [W-1:0] d, logic ti, logic q, logic m);
        exp_t e;
        logic [W:0] x;
        logic [W-1:0] sh;
        sh = {r[W-2:0], ti};
        if (q == m) x = {1'b0, sh} - {1'b0, d};
        else        x = {1'b0, sh} + {1'b0, d};
        e.rem = x[W-1:0];
        e.q   = r[W-1] ^ x[W] ^ m;
        e.m   = m;
        e.t   = (e.q == m);
        e.tag = "R4/R5/R6 step";
        return e;
    endfunction

    // Monitor: pop and compare at each result pulse.
    always @(posedge clk) begin
        #5;
        if (res_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7/R8 unexpected res_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({rem_out, q_out, m_out, t_out} == {e.rem, e.q, e.m, e.t}, e.tag,
                    {rem_out, q_out, m_out, t_out}, {e.rem, e.q, e.m, e.t});
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic [W-1:0] d, input logic [W-1:0] r,
                         input logic ti, input exp_t e, input bit push);
        if (push) sb.push_back(e);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; divisor = d; rem_in = r; t_in = ti;
        @(negedge clk);
        op_valid = 1'b0;
        if (push) chk(sb.size() == 0, "R7 result one cycle after issue", sb.size(), 0);
        if (push) begin mq = e.q; mm = e.m; end
    endtask

    task automatic run_div(input logic [W-1:0] n, input logic [W-1:0] dv);
        exp_t e;
        logic [W-1:0] hi, lo;
        logic bt, sb_bit;
        e.rem = '0; e.q = 0; e.m = 0; e.t = 0; e.tag = "R2 unsigned setup";
        issue(2'b01, dv, '0, 1'b1, e, 1);
        hi = rem_out; lo = n; bt = t_out;
        for (int i = 0; i < W; i++) begin
            sb_bit = lo[W-1];
            lo = {lo[W-2:0], bt};
            e = model_step(hi, dv, sb_bit, mq, mm);
            issue(2'b00, dv, hi, sb_bit, e, 1);
            hi = rem_out; bt = t_out;
        end
        lo = {lo[W-2:0], bt};
        chk(lo == n / dv, "R9 assembled quotient", {3'b0, lo}, {3'b0, n / dv});
    endtask

    task automatic run_signed(input logic [W-1:0] r, input logic [W-1:0] d);
        exp_t e;
        e.rem = r; e.q = r[W-1]; e.m = d[W-1]; e.t = r[W-1] ^ d[W-1]; e.tag = "R3 signed setup";
        issue(2'b10, d, r, 1'b0, e, 1);
        e = model_step(r, d, 1'b1, mq, mm);
        issue(2'b00, d, r, 1'b1, e, 1);
        e = model_step(r ^ 32'h5a5a_0f0f, d, 1'b0, mq, mm);
        issue(2'b00, d, r ^ 32'h5a5a_0f0f, 1'b0, e, 1);
    endtask

    initial begin
        exp_t e;
        logic [W+2:0] snap;
        repeat (3) @(negedge clk);
        chk({res_valid, rem_out, q_out, m_out, t_out} == '0, "R1 reset state",
            {rem_out, q_out, m_out, t_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div(32'd100, 32'd7);
        run_div(32'hFFFF_FFFF, 32'd1);
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_div(32'd5, 32'd9);
        run_div(32'h8000_0000, 32'd3);
        run_div(32'd0, 32'd5);
        run_div(32'd123456789, 32'd1000);
        run_div(32'hDEAD_BEEF, 32'h8000_0001);

        run_signed(32'h0000_1234, 32'h0000_0100);
        run_signed(32'h8000_0010, 32'h0000_0005);
        run_signed(32'h0000_0007, 32'hFFFF_FFF0);
        run_signed(32'hF000_0000, 32'h8000_0001);

        // R8: reserved op and idle cycles leave state untouched.
        snap = {rem_out, q_out, m_out, t_out};
        issue(2'b11, 32'h1234_5678, 32'hCAFE_F00D, 1'b1, e, 0);
        chk({rem_out, q_out, m_out, t_out} == snap, "R8 reserved op ignored",
            {rem_out, q_out, m_out, t_out}, snap);
        @(negedge clk);
        rem_in = 32'h0F0F_0F0F; divisor = 32'h1;
        repeat (3) @(negedge clk);
        chk({rem_out, q_out, m_out, t_out} == snap && !res_valid, "R8 idle holds",
            {rem_out, q_out, m_out, t_out}, snap);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule